// File: doc/BRIEF.md
# I2C Controller Halt and Timeout Supervisor

This block sits beside the bit-level state machine of an I2C controller and decides when that controller has to stop. It watches the sampled SCL line, the controller's own SCL pull-down and the activity of the state machine. From these it measures clock-low time in one of two ways. In stretch mode it counts only the time that some other device holds SCL low. In bus mode it counts the whole low period, including the controller's own low phase. A bus-mode expiry halts the controller. A stretch-mode expiry only produces an informational interrupt pulse.

The supervisor also reacts to protocol faults. A NACK on a byte the controller transmitted halts it, unless that byte was marked as NACK-tolerated. A lost arbitration halts it too. Each cause is latched in its own event bit, and software clears that bit by writing a 1 to it. While the controller sits halted on a NACK, a backstop timer runs. If software does not handle the NACK in time, the supervisor asks the state machine to issue a STOP. It then latches a second event, which keeps the controller halted in idle until software clears that event. The halt output is a level: it stays high while any event bit is set, and it also serves as the halt interrupt.

Top module: `i2c_halt_supervisor`

## Requirements
- R1: After reset all four event bits, `halt_o`, `stop_req_o` and `stretch_tmo_o` are 0.
- R2: Bus mode counts every cycle in which `fsm_active_i`=1 and `scl_sense_i`=0, whatever `scl_drive_low_i` is. The conditions are `tmo_en_i`=1, `tmo_mode_i`=1 and `tmo_limit_i`=L≠0. After L such consecutive cycles, event bit 2 (bus timeout) is 1 on the following clock edge. After L-1 cycles it is still 0.
- R3: Stretch mode (`tmo_mode_i`=0) counts only the cycles in which SCL is low while the controller is not driving it low. During the controller's own low cycles the count holds its value. On expiry `stretch_tmo_o` is high for exactly one cycle, and no event bit is set.
- R4: With `tmo_en_i`=0, or with `tmo_limit_i`=0, no clock-low timeout of either mode occurs, however long SCL stays low.
- R5: The clock-low count returns to zero whenever SCL is high or `fsm_active_i` is 0.
- R6: A `nack_rx_i` strobe with `nack_ok_i`=0 sets event bit 0 (NACK). With `nack_ok_i`=1 the strobe sets no event.
- R7: While bit 0 is set and bit 1 is clear, the backstop timer counts, provided `nack_tmo_en_i`=1 and `nack_tmo_limit_i`=N≠0. After N cycles, bit 1 (unhandled-NACK timeout) and a one-cycle `stop_req_o` pulse appear together. The pulse comes once per halt.
- R8: The backstop never expires when `nack_tmo_en_i`=0 or its limit is 0. Its count restarts whenever bit 0 is clear.
- R9: An `arb_lost_i` strobe sets event bit 3 (arbitration lost).
- R10: A 1 in bit i of `evt_clr_i` clears event bit i on the next edge. It leaves the other bits alone. If a new cause for a bit arrives in the same cycle as its clear, the bit stays set.
- R11: `halt_o` is 1 exactly while any event bit is 1. After a backstop STOP it stays 1 until bit 1 is cleared, even if bit 0 was cleared first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmo_en_i | input | 1 | Clock-low timeout enable |
| tmo_mode_i | input | 1 | 0: stretch counting, 1: whole-low-period counting |
| tmo_limit_i | input | TMO_W (30) | Clock-low timeout in cycles, 0 disables |
| nack_tmo_en_i | input | 1 | Backstop timer enable |
| nack_tmo_limit_i | input | NACK_W (31) | Backstop timeout in cycles, 0 disables |
| scl_drive_low_i | input | 1 | Controller is pulling SCL low |
| scl_sense_i | input | 1 | Sampled SCL level |
| fsm_active_i | input | 1 | Controller state machine is in a transaction |
| nack_rx_i | input | 1 | Strobe: a transmitted byte was NACKed |
| nack_ok_i | input | 1 | The current byte tolerates a NACK |
| arb_lost_i | input | 1 | Strobe: arbitration lost |
| evt_clr_i | input | 4 | Write-1-to-clear strobes, one per event bit |
| events_o | output | 4 | Event bits: 0 NACK, 1 unhandled-NACK timeout, 2 bus timeout, 3 arbitration lost |
| halt_o | output | 1 | Halt request and level halt interrupt |
| stop_req_o | output | 1 | One-cycle request to issue a STOP |
| stretch_tmo_o | output | 1 | One-cycle stretch-timeout interrupt pulse |

## Verification
The assertions watch four rules on every cycle. They check that a cleared event bit drops unless a new cause arrives, and that an uncleared bit holds. They check that a clear condition empties a timer, that the STOP request lasts one cycle and always comes with the backstop event, and that no stretch pulse appears while the timeout is disabled or in bus mode. The exact expiry cycle of each timer can only be shown by the bench scenarios. The same goes for the count holding during the controller's own low phase, the restart on SCL high or inactivity, the NACK-tolerated exemption and the halt persisting after a backstop STOP.

// File: rtl/i2c_halt_pkg.sv
package i2c_halt_pkg;
   localparam int unsigned EV_NACK     = 0;
   localparam int unsigned EV_NACK_TMO = 1;
   localparam int unsigned EV_BUS_TMO  = 2;
   localparam int unsigned EV_ARB_LOST = 3;
   localparam int unsigned EV_COUNT    = 4;
   typedef logic [EV_COUNT-1:0] ev_vec_t;
endpackage

// File: rtl/i2c_sup_timer.sv
module i2c_sup_timer #(
   parameter int unsigned CNT_W = 30
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             fire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("i2c_sup_timer: CNT_W must lie in 2..32");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             armed;

   assign armed  = (limit_i != '0);
   assign fire_o = run_i && !clr_i && armed && (cnt_q == limit_i - ONE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (run_i && armed && cnt_q < limit_i) begin
         cnt_q <= cnt_q + ONE;
      end
   end

   // R5: a clear condition empties the counter on the next edge
   assert_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> cnt_q == '0);
   // R3: without run the count neither moves nor restarts
   assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !run_i) |=> $stable(cnt_q));
endmodule

// File: rtl/i2c_sup_events.sv
module i2c_sup_events
   import i2c_halt_pkg::*;
(
   input  logic    clk_i,
   input  logic    rst_ni,
   input  ev_vec_t set_i,
   input  ev_vec_t clr_i,
   output ev_vec_t ev_o
);
   ev_vec_t ev_q;

   for (genvar b = 0; b < EV_COUNT; b++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)          ev_q[b] <= 1'b0;
         else if (set_i[b])    ev_q[b] <= 1'b1;
         else if (clr_i[b])    ev_q[b] <= 1'b0;
      end

      // R10: clear without a new cause drops the bit
      assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (clr_i[b] && !set_i[b]) |=> !ev_q[b]);
      // R10: an uncleared bit stays latched
      assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ev_q[b] && !clr_i[b]) |=> ev_q[b]);
   end

   assign ev_o = ev_q;
endmodule

// File: rtl/i2c_halt_supervisor.sv
module i2c_halt_supervisor
   import i2c_halt_pkg::*;
#(
   parameter int unsigned TMO_W  = 30,
   parameter int unsigned NACK_W = 31
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tmo_en_i,
   input  logic              tmo_mode_i,
   input  logic [TMO_W-1:0]  tmo_limit_i,
   input  logic              nack_tmo_en_i,
   input  logic [NACK_W-1:0] nack_tmo_limit_i,
   input  logic              scl_drive_low_i,
   input  logic              scl_sense_i,
   input  logic              fsm_active_i,
   input  logic              nack_rx_i,
   input  logic              nack_ok_i,
   input  logic              arb_lost_i,
   input  logic [3:0]        evt_clr_i,
   output logic [3:0]        events_o,
   output logic              halt_o,
   output logic              stop_req_o,
   output logic              stretch_tmo_o
);
   generate
      if (EV_COUNT != 4) begin : g_bad_events
         $error("i2c_halt_supervisor: event vector must be 4 bits");
      end
   endgenerate

   ev_vec_t ev;
   ev_vec_t ev_set;

   // clock-low timer: bus mode counts all low time, stretch mode only foreign low
   logic low_run, low_clr, low_fire;
   assign low_run = tmo_mode_i | ~scl_drive_low_i;
   assign low_clr = ~(tmo_en_i & fsm_active_i & ~scl_sense_i);

   i2c_sup_timer #(.CNT_W(TMO_W)) u_low_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (low_run),
      .clr_i   (low_clr),
      .limit_i (tmo_limit_i),
      .fire_o  (low_fire)
   );

   // backstop timer: runs while halted on a NACK that has not yet timed out
   logic bs_run, bs_clr, bs_fire;
   assign bs_run = nack_tmo_en_i & ev[EV_NACK] & ~ev[EV_NACK_TMO];
   assign bs_clr = ~ev[EV_NACK];

   i2c_sup_timer #(.CNT_W(NACK_W)) u_backstop (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (bs_run),
      .clr_i   (bs_clr),
      .limit_i (nack_tmo_limit_i),
      .fire_o  (bs_fire)
   );

   always_comb begin
      ev_set              = '0;
      ev_set[EV_NACK]     = nack_rx_i & ~nack_ok_i;
      ev_set[EV_NACK_TMO] = bs_fire;
      ev_set[EV_BUS_TMO]  = low_fire & tmo_mode_i;
      ev_set[EV_ARB_LOST] = arb_lost_i;
   end

   i2c_sup_events u_events (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (ev_set),
      .clr_i  (evt_clr_i),
      .ev_o   (ev)
   );

   logic stop_q, stretch_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stop_q    <= 1'b0;
         stretch_q <= 1'b0;
      end else begin
         stop_q    <= bs_fire;
         stretch_q <= low_fire & ~tmo_mode_i;
      end
   end

   assign events_o      = ev;
   assign halt_o        = |ev;
   assign stop_req_o    = stop_q;
   assign stretch_tmo_o = stretch_q;

   // R7: the STOP request is a single-cycle pulse
   assert_stop_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_req_o |=> !stop_req_o);
   // R7: the STOP request always coincides with the backstop event
   assert_stop_event_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_req_o |-> events_o[EV_NACK_TMO]);
   // R4: no stretch pulse follows a cycle with the timeout disabled
   assert_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tmo_en_i |=> !stretch_tmo_o);
   // R3: bus mode never produces a stretch pulse
   assert_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmo_mode_i |=> !stretch_tmo_o);
endmodule

// File: tb/i2c_halt_supervisor_test.sv
module i2c_halt_supervisor_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tmo_en = 1'b0, tmo_mode = 1'b0;
   logic [29:0] tmo_limit = '0;
   logic        nack_en = 1'b0;
   logic [30:0] nack_limit = '0;
   logic        drive_low = 1'b0, scl = 1'b1, active = 1'b0;
   logic        nack_rx = 1'b0, nack_ok = 1'b0, arb = 1'b0;
   logic [3:0]  clr = '0;
   logic [3:0]  ev;
   logic        halt, stop_req, stretch;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   i2c_halt_supervisor uut (
      .clk_i(clk), .rst_ni(rst_n),
      .tmo_en_i(tmo_en), .tmo_mode_i(tmo_mode), .tmo_limit_i(tmo_limit),
      .nack_tmo_en_i(nack_en), .nack_tmo_limit_i(nack_limit),
      .scl_drive_low_i(drive_low), .scl_sense_i(scl), .fsm_active_i(active),
      .nack_rx_i(nack_rx), .nack_ok_i(nack_ok), .arb_lost_i(arb),
      .evt_clr_i(clr), .events_o(ev), .halt_o(halt),
      .stop_req_o(stop_req), .stretch_tmo_o(stretch)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic clear_all();
      scl = 1'b1; active = 1'b0; drive_low = 1'b0;
      clr = 4'hF; step(1); clr = 4'h0; step(1);
   endtask

   task automatic t_reset();
      chk("R1 events", ev, 0);
      chk("R1 halt", halt, 0);
      chk("R1 stop", stop_req, 0);
      chk("R1 stretch", stretch, 0);
   endtask

   task automatic t_bus_mode();
      tmo_en = 1; tmo_mode = 1; tmo_limit = 5;
      active = 1; scl = 0; drive_low = 1;
      step(3); drive_low = 0; step(1);
      chk("R2 not yet", ev[2], 0);
      step(1);
      chk("R2 bus event", ev[2], 1);
      chk("R11 halt", halt, 1);
      scl = 1; step(1);
      clr = 4'b0100; step(1); clr = 0;
      chk("R10 cleared", ev[2], 0);
      chk("R11 halt low", halt, 0);
   endtask

   task automatic t_stretch_mode();
      int pulses = 0;
      tmo_mode = 0; tmo_limit = 5; active = 1; scl = 0;
      drive_low = 1;
      for (int i = 0; i < 10; i++) begin step(1); pulses += int'(stretch); end
      drive_low = 0; step(3);
      drive_low = 1;
      for (int i = 0; i < 4; i++) begin step(1); pulses += int'(stretch); end
      chk("R3 no pulse own low", pulses, 0);
      drive_low = 0; step(1);
      chk("R3 held count, no pulse yet", stretch, 0);
      step(1);
      chk("R3 pulse", stretch, 1);
      step(1);
      chk("R3 single cycle", stretch, 0);
      chk("R3 no event", ev, 0);
      chk("R3 no halt", halt, 0);
      clear_all();
   endtask

   task automatic t_disabled();
      tmo_mode = 1; tmo_limit = 3; tmo_en = 0; active = 1; scl = 0;
      step(20);
      chk("R4 enable off", ev[2], 0);
      tmo_en = 1; tmo_limit = 0; step(20);
      chk("R4 zero limit", ev[2], 0);
      tmo_mode = 0; step(5);
      chk("R4 zero limit stretch", stretch, 0);
      clear_all();
   endtask

   task automatic t_restart();
      tmo_en = 1; tmo_mode = 1; tmo_limit = 5; active = 1; scl = 0;
      step(4); scl = 1; step(1); scl = 0; step(4);
      chk("R5 scl high restarts", ev[2], 0);
      active = 0; step(1); active = 1; step(4);
      chk("R5 inactive restarts", ev[2], 0);
      step(1);
      chk("R5 full window fires", ev[2], 1);
      clear_all();
   endtask

   task automatic t_nack();
      nack_en = 0; nack_ok = 1; nack_rx = 1; step(1); nack_rx = 0;
      chk("R6 tolerated", ev, 0);
      nack_ok = 0; nack_rx = 1; step(1); nack_rx = 0;
      chk("R6 nack event", ev, 4'b0001);
      step(20);
      chk("R8 backstop off", ev[1], 0);
      clear_all();
   endtask

   task automatic t_backstop();
      nack_en = 1; nack_limit = 3;
      nack_rx = 1; step(1); nack_rx = 0;
      step(1);
      clr = 4'b0001; step(1); clr = 0;
      nack_rx = 1; step(1); nack_rx = 0;
      step(1);
      chk("R8 restart after clear", ev[1], 0);
      clear_all();
      nack_rx = 1; step(1); nack_rx = 0;
      chk("R7 nack set", ev[0], 1);
      step(2);
      chk("R7 before expiry", ev[1], 0);
      step(1);
      chk("R7 timeout event", ev[1], 1);
      chk("R7 stop pulse", stop_req, 1);
      step(1);
      chk("R7 stop one cycle", stop_req, 0);
      step(10);
      chk("R7 no second stop", stop_req, 0);
      clr = 4'b0001; step(1); clr = 0;
      chk("R11 still halted", halt, 1);
      clr = 4'b0010; step(1); clr = 0;
      chk("R11 released", halt, 0);
      nack_limit = 0;
      nack_rx = 1; step(1); nack_rx = 0; step(10);
      chk("R8 zero limit", ev[1], 0);
      nack_en = 0;
      clear_all();
   endtask

   task automatic t_arb_and_w1c();
      arb = 1; step(1); arb = 0;
      chk("R9 arb event", ev, 4'b1000);
      nack_rx = 1; step(1); nack_rx = 0;
      clr = 4'b1000; step(1); clr = 0;
      chk("R10 selective clear", ev, 4'b0001);
      arb = 1; step(1); arb = 0;
      arb = 1; clr = 4'b1000; step(1); arb = 0; clr = 0;
      chk("R10 set wins", ev[3], 1);
      clear_all();
      chk("R10 all cleared", ev, 0);
   endtask

   initial begin
      step(2); rst_n = 1'b1; step(1);
      t_reset();
      t_bus_mode();
      t_stretch_mode();
      t_disabled();
      t_restart();
      t_nack();
      t_backstop();
      t_arb_and_w1c();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule